// File: doc/BRIEF.md
# Dual-Read General Register File with Zero/Stack-Pointer Aliasing

This block holds the 64-bit general registers of a processor core together with its program-counter pair. It offers two independent combinational read ports and one clocked write port. Every access carries its own select that decides what index 31 means for that access: with the select high, index 31 is a real stack-pointer register; with it low, index 31 is a zero source that reads as zero and swallows writes.

Reads can return the whole 64-bit register or only its low 32, 16 or 8 bits, widened either with zeros or with copies of the top bit of the narrow field. Writes store either 64 bits or 32 bits, and a 32-bit write clears the upper half of the register.

The sequencing part keeps the current PC and the next PC. A commit strobe moves the next PC into the current PC and, unless a branch target is being loaded, advances the next PC by 4. A branch target can be loaded as an absolute address or as the current PC plus a signed offset. A link-save strobe copies the next PC into register 30 so that a call can record its return address before the target is installed.

Top module: `gpr_file`

## Requirements
- R1: A read of index 31 with that port's stack-pointer select low returns zero, whatever the stack-pointer register holds.
- R2: A write to index 31 with the write stack-pointer select low changes no register; with the select high it updates the stack-pointer register, which a read of index 31 with the select high returns.
- R3: A 64-bit write (`wr_narrow`=0) stores all 64 bits at the rising edge; a read in the same cycle returns the old value and the new value is visible from the next cycle.
- R4: A 32-bit write (`wr_narrow`=1) stores `wr_data[31:0]` in bits 31:0 and clears bits 63:32.
- R5: Read size encoding: 0 = 64 bits, 1 = low 32 bits, 2 = low 16 bits, 3 = low 8 bits. With the signed select low the upper bits are zero; with it high they copy the top bit of the selected field.
- R6: A commit copies the next PC into the current PC at the rising edge; without a commit the current PC holds.
- R7: A commit with no target load sets the next PC to its previous value plus 4.
- R8: An absolute load sets the next PC to `nxt_target`; a relative load sets it to the current PC plus `nxt_target` taken as a signed offset. Absolute wins when both are high, and either load overrides the step of R7 in a commit cycle; the relative load uses the PC before that commit.
- R9: A link save writes the next-PC value present before the edge into register 30, and wins over a register write to index 30 in the same cycle.
- R10: Synchronous reset clears all registers, the stack pointer, the PC and the next PC to zero.
- R11: The two read ports are independent: each returns its own index, size, sign and stack-pointer choice in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_sp | input | 1 | Port A: index 31 is the stack pointer when high, zero when low |
| rd_a_size | input | 2 | Port A read size (0=64, 1=32, 2=16, 3=8 bits) |
| rd_a_signed | input | 1 | Port A sign-extends a narrow read when high |
| rd_a_data | output | 64 | Port A read data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_sp | input | 1 | Port B stack-pointer select for index 31 |
| rd_b_size | input | 2 | Port B read size |
| rd_b_signed | input | 1 | Port B sign-extends a narrow read when high |
| rd_b_data | output | 64 | Port B read data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_sp | input | 1 | Write stack-pointer select for index 31 |
| wr_narrow | input | 1 | 32-bit write with upper-half clear when high |
| wr_data | input | 64 | Write data |
| nxt_load_abs | input | 1 | Load the next PC with an absolute target |
| nxt_load_rel | input | 1 | Load the next PC with current PC plus signed offset |
| nxt_target | input | 64 | Absolute target or signed offset |
| commit | input | 1 | Move the next PC into the current PC |
| link_save | input | 1 | Copy the next PC into register 30 |
| pc_out | output | 64 | Current PC |
| next_pc_out | output | 64 | Next PC |

## Verification
The bench chases index 31 under both select values on reads and writes: a design that ignored the select would leak the stack pointer into zero reads or let zero-register writes corrupt it. It drives 32-bit writes over registers full of ones and narrow reads with set top bits, which expose a missing upper-half clear or a sign copied from the wrong bit. It collides link saves with writes to register 30 and loads with commits, where a wrong priority puts the write data in the link register, adds the step on top of a branch, or takes the relative base after the commit instead of before it.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;

    localparam int XLEN     = 64;
    localparam int HALFW    = XLEN / 2;
    localparam int NREG     = 32;
    localparam int IDXW     = $clog2(NREG);
    localparam int SP_IDX   = NREG - 1;
    localparam int LINK_IDX = NREG - 2;
    localparam int PC_STEP  = 4;
    localparam int NRD      = 2;

    typedef enum logic [1:0] {
        ACC_D = 2'd0,
        ACC_W = 2'd1,
        ACC_H = 2'd2,
        ACC_B = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [IDXW-1:0] idx;
        logic            sp_sel;
        acc_size_e       size;
        logic            sext;
    } rd_req_t;

    typedef struct packed {
        logic            en;
        logic [IDXW-1:0] idx;
        logic            sp_sel;
        logic            narrow;
        logic [XLEN-1:0] data;
    } wr_req_t;

    // Index 31 behaves as a zero source when the access does not select the stack pointer.
    function automatic logic zero_alias(logic [IDXW-1:0] idx, logic sp_sel);
        return (idx == IDXW'(SP_IDX)) && !sp_sel;
    endfunction

    // Widen the low field of a register to the full width.
    function automatic logic [XLEN-1:0] widen(logic [XLEN-1:0] raw, acc_size_e size, logic sext);
        logic [XLEN-1:0] res;
        case (size)
            ACC_W:   res = sext ? {{(XLEN-32){raw[31]}}, raw[31:0]} : {{(XLEN-32){1'b0}}, raw[31:0]};
            ACC_H:   res = sext ? {{(XLEN-16){raw[15]}}, raw[15:0]} : {{(XLEN-16){1'b0}}, raw[15:0]};
            ACC_B:   res = sext ? {{(XLEN-8){raw[7]}},   raw[7:0]}  : {{(XLEN-8){1'b0}},  raw[7:0]};
            default: res = raw;
        endcase
        return res;
    endfunction

    // Value stored by a write: a narrow write clears the upper half.
    function automatic logic [XLEN-1:0] store_value(logic [XLEN-1:0] data, logic narrow);
        return narrow ? {{(XLEN-HALFW){1'b0}}, data[HALFW-1:0]} : data;
    endfunction

endpackage

// File: rtl/gpr_store.sv
`timescale 1ns/1ps
module gpr_store
    import gpr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  wr_req_t         wr,
    input  logic            link_en,
    input  logic [XLEN-1:0] link_val,
    output logic [XLEN-1:0] regs [NREG]
);

    logic            wr_ok;
    logic [XLEN-1:0] wr_val;

    always_comb begin
        wr_ok  = wr.en && !zero_alias(wr.idx, wr.sp_sel);
        wr_val = store_value(wr.data, wr.narrow);
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit;
        always_comb hit = wr_ok && (wr.idx == IDXW'(g));

        if (g == LINK_IDX) begin : g_link
            always_ff @(posedge clk) begin
                if (rst)          regs[g] <= '0;
                else if (link_en) regs[g] <= link_val;
                else if (hit)     regs[g] <= wr_val;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)      regs[g] <= '0;
                else if (hit) regs[g] <= wr_val;
            end
        end
    end

endmodule

// File: rtl/gpr_read_port.sv
`timescale 1ns/1ps
module gpr_read_port
    import gpr_pkg::*;
(
    input  logic [XLEN-1:0] regs [NREG],
    input  rd_req_t         req,
    output logic [XLEN-1:0] data
);

    logic [XLEN-1:0] raw;

    always_comb begin
        raw  = zero_alias(req.idx, req.sp_sel) ? '0 : regs[req.idx];
        data = widen(raw, req.size, req.sext);
    end

endmodule

// File: rtl/pc_seq.sv
`timescale 1ns/1ps
module pc_seq
    import gpr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            commit,
    input  logic            load_abs,
    input  logic            load_rel,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] npc_q
);

    logic [XLEN-1:0] npc_d;
    logic [XLEN-1:0] pc_d;

    always_comb begin
        pc_d = commit ? npc_q : pc_q;
        if (load_abs)      npc_d = target;
        else if (load_rel) npc_d = pc_q + target;
        else if (commit)   npc_d = npc_q + XLEN'(PC_STEP);
        else               npc_d = npc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            npc_q <= '0;
        end else begin
            pc_q  <= pc_d;
            npc_q <= npc_d;
        end
    end

endmodule

// File: rtl/gpr_file.sv
`timescale 1ns/1ps
module gpr_file
    import gpr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  rd_a_idx,
    input  logic        rd_a_sp,
    input  logic [1:0]  rd_a_size,
    input  logic        rd_a_signed,
    output logic [63:0] rd_a_data,
    input  logic [4:0]  rd_b_idx,
    input  logic        rd_b_sp,
    input  logic [1:0]  rd_b_size,
    input  logic        rd_b_signed,
    output logic [63:0] rd_b_data,
    input  logic        wr_en,
    input  logic [4:0]  wr_idx,
    input  logic        wr_sp,
    input  logic        wr_narrow,
    input  logic [63:0] wr_data,
    input  logic        nxt_load_abs,
    input  logic        nxt_load_rel,
    input  logic [63:0] nxt_target,
    input  logic        commit,
    input  logic        link_save,
    output logic [63:0] pc_out,
    output logic [63:0] next_pc_out
);

    logic [XLEN-1:0] regs [NREG];
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] npc_q;
    wr_req_t         wr;
    rd_req_t         rreq  [NRD];
    logic [XLEN-1:0] rdata [NRD];

    always_comb begin
        wr.en     = wr_en;
        wr.idx    = wr_idx;
        wr.sp_sel = wr_sp;
        wr.narrow = wr_narrow;
        wr.data   = wr_data;

        rreq[0].idx    = rd_a_idx;
        rreq[0].sp_sel = rd_a_sp;
        rreq[0].size   = acc_size_e'(rd_a_size);
        rreq[0].sext   = rd_a_signed;

        rreq[1].idx    = rd_b_idx;
        rreq[1].sp_sel = rd_b_sp;
        rreq[1].size   = acc_size_e'(rd_b_size);
        rreq[1].sext   = rd_b_signed;
    end

    gpr_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .link_en  (link_save),
        .link_val (npc_q),
        .regs     (regs)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        gpr_read_port u_rd (
            .regs (regs),
            .req  (rreq[p]),
            .data (rdata[p])
        );
    end

    pc_seq u_pc (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .load_abs (nxt_load_abs),
        .load_rel (nxt_load_rel),
        .target   (nxt_target),
        .pc_q     (pc_q),
        .npc_q    (npc_q)
    );

    assign rd_a_data   = rdata[0];
    assign rd_b_data   = rdata[1];
    assign pc_out      = pc_q;
    assign next_pc_out = npc_q;

endmodule

// File: rtl/gpr_file_chk.sv
`timescale 1ns/1ps
module gpr_file_chk (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  rd_a_idx,
    input logic        rd_a_sp,
    input logic [1:0]  rd_a_size,
    input logic        rd_a_signed,
    input logic [63:0] rd_a_data,
    input logic [4:0]  rd_b_idx,
    input logic        rd_b_sp,
    input logic [63:0] rd_b_data,
    input logic        nxt_load_abs,
    input logic        nxt_load_rel,
    input logic [63:0] nxt_target,
    input logic        commit,
    input logic [63:0] pc_out,
    input logic [63:0] next_pc_out
);

    p_zero_read_a_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 5'd31 && !rd_a_sp) |-> (rd_a_data == 64'd0));

    p_zero_read_b_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == 5'd31 && !rd_b_sp) |-> (rd_b_data == 64'd0));

    p_unsigned_word_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_a_size == 2'd1 && !rd_a_signed) |-> (rd_a_data[63:32] == 32'd0));

    p_byte_sext_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_a_size == 2'd3 && rd_a_signed) |-> (rd_a_data[63:8] == {56{rd_a_data[7]}}));

    p_commit_moves_r6: assert property (@(posedge clk) disable iff (rst)
        commit |=> (pc_out == $past(next_pc_out)));

    p_pc_holds_r6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(pc_out));

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (commit && !nxt_load_abs && !nxt_load_rel) |=> (next_pc_out == $past(next_pc_out) + 64'd4));

    p_abs_load_r8: assert property (@(posedge clk) disable iff (rst)
        nxt_load_abs |=> (next_pc_out == $past(nxt_target)));

    p_rel_load_r8: assert property (@(posedge clk) disable iff (rst)
        (nxt_load_rel && !nxt_load_abs) |=> (next_pc_out == $past(pc_out) + $past(nxt_target)));

endmodule

bind gpr_file gpr_file_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_a_idx     (rd_a_idx),
    .rd_a_sp      (rd_a_sp),
    .rd_a_size    (rd_a_size),
    .rd_a_signed  (rd_a_signed),
    .rd_a_data    (rd_a_data),
    .rd_b_idx     (rd_b_idx),
    .rd_b_sp      (rd_b_sp),
    .rd_b_data    (rd_b_data),
    .nxt_load_abs (nxt_load_abs),
    .nxt_load_rel (nxt_load_rel),
    .nxt_target   (nxt_target),
    .commit       (commit),
    .pc_out       (pc_out),
    .next_pc_out  (next_pc_out)
);

// File: tb/tb_gpr_file.sv
`timescale 1ns/1ps
module tb_gpr_file;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_a_idx,  rd_b_idx, wr_idx;
    logic        rd_a_sp,   rd_b_sp,  wr_sp;
    logic [1:0]  rd_a_size, rd_b_size;
    logic        rd_a_signed, rd_b_signed;
    logic [63:0] rd_a_data, rd_b_data;
    logic        wr_en, wr_narrow;
    logic [63:0] wr_data;
    logic        nxt_load_abs, nxt_load_rel;
    logic [63:0] nxt_target;
    logic        commit, link_save;
    logic [63:0] pc_out, next_pc_out;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [63:0] m_reg [32];
    logic [63:0] m_pc, m_npc;

    always #10 clk = ~clk;

    gpr_file dut (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_read(logic [4:0] idx, logic sp, logic [1:0] sz, logic sg);
        logic [63:0] raw;
        raw = (idx == 5'd31 && !sp) ? 64'd0 : m_reg[idx];
        case (sz)
            2'd1:    return sg ? {{32{raw[31]}}, raw[31:0]} : {32'd0, raw[31:0]};
            2'd2:    return sg ? {{48{raw[15]}}, raw[15:0]} : {48'd0, raw[15:0]};
            2'd3:    return sg ? {{56{raw[7]}},  raw[7:0]}  : {56'd0, raw[7:0]};
            default: return raw;
        endcase
    endfunction

    function automatic string auto_tag(logic [4:0] idx, logic sp, logic [1:0] sz);
        if (idx == 5'd31 && !sp) return "R1";
        if (sz != 2'd0)          return "R5";
        return "R3";
    endfunction

    task automatic idle();
        wr_en = 0; wr_idx = 0; wr_sp = 0; wr_narrow = 0; wr_data = 0;
        nxt_load_abs = 0; nxt_load_rel = 0; nxt_target = 0;
        commit = 0; link_save = 0;
        rd_a_idx = 0; rd_a_sp = 0; rd_a_size = 0; rd_a_signed = 0;
        rd_b_idx = 0; rd_b_sp = 0; rd_b_size = 0; rd_b_signed = 0;
    endtask

    // Check outputs mid-cycle against the model, then advance the model with the edge.
    task automatic cycle(string tag);
        logic [63:0] old_pc, old_npc;
        #1;
        chk(tag != "" ? tag : auto_tag(rd_a_idx, rd_a_sp, rd_a_size), rd_a_data,
            ref_read(rd_a_idx, rd_a_sp, rd_a_size, rd_a_signed));
        chk(tag != "" ? tag : "R11", rd_b_data,
            ref_read(rd_b_idx, rd_b_sp, rd_b_size, rd_b_signed));
        chk(tag != "" ? tag : "R6", pc_out, m_pc);
        chk(tag != "" ? tag : "R7", next_pc_out, m_npc);
        @(posedge clk);
        old_pc  = m_pc;
        old_npc = m_npc;
        if (wr_en && !(wr_idx == 5'd31 && !wr_sp) && !(link_save && wr_idx == 5'd30))
            m_reg[wr_idx] = wr_narrow ? {32'd0, wr_data[31:0]} : wr_data;
        if (link_save) m_reg[30] = old_npc;
        if (commit) m_pc = old_npc;
        if (nxt_load_abs)      m_npc = nxt_target;
        else if (nxt_load_rel) m_npc = old_pc + nxt_target;
        else if (commit)       m_npc = old_npc + 64'd4;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        for (int i = 0; i < 32; i++) m_reg[i] = 64'd0;
        m_pc = 0; m_npc = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R10: everything reads zero after reset
        for (int i = 0; i < 32; i++) begin
            idle(); rd_a_idx = 5'(i); rd_a_sp = 1; rd_b_idx = 5'(31 - i); rd_b_sp = 1;
            cycle("R10");
        end

        // R2: write to index 31 without select is dropped
        idle(); wr_en = 1; wr_idx = 31; wr_sp = 0; wr_data = 64'hDEAD_BEEF_0000_1111;
        cycle("R2");
        idle(); rd_a_idx = 31; rd_a_sp = 1;
        #1; chk("R2", rd_a_data, 64'd0); @(negedge clk);
        idle(); wr_en = 1; wr_idx = 31; wr_sp = 1; wr_data = 64'h0000_7FFF_FFF0_0000;
        rd_a_idx = 31; rd_a_sp = 1;
        #1; chk("R3", rd_a_data, 64'd0); // old value during the write cycle
        cycle("R2");
        idle(); rd_a_idx = 31; rd_a_sp = 1; rd_b_idx = 31; rd_b_sp = 0;
        #1; chk("R2", rd_a_data, 64'h0000_7FFF_FFF0_0000);
        chk("R1", rd_b_data, 64'd0);
        @(negedge clk);

        // R4: narrow write clears the upper half
        idle(); wr_en = 1; wr_idx = 5; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        cycle("R3");
        idle(); wr_en = 1; wr_idx = 5; wr_narrow = 1; wr_data = 64'hABCD_0123_8000_0081;
        cycle("R4");
        idle(); rd_a_idx = 5; rd_b_idx = 5; rd_b_size = 1; rd_b_signed = 1;
        #1; chk("R4", rd_a_data, 64'h0000_0000_8000_0081);
        chk("R5", rd_b_data, 64'hFFFF_FFFF_8000_0081);
        @(negedge clk);
        idle(); rd_a_idx = 5; rd_a_size = 3; rd_a_signed = 1; rd_b_idx = 5; rd_b_size = 2;
        #1; chk("R5", rd_a_data, 64'hFFFF_FFFF_FFFF_FF81);
        chk("R11", rd_b_data, 64'h0000_0000_0000_0081);
        @(negedge clk);

        // R7 / R6: plain commits step by 4
        idle(); commit = 1; cycle("R7");
        idle(); commit = 1; cycle("R7");
        idle(); #1; chk("R6", pc_out, 64'd4); chk("R7", next_pc_out, 64'd8); @(negedge clk);

        // R8: absolute beats relative, load overrides step in commit cycle
        idle(); commit = 1; nxt_load_abs = 1; nxt_load_rel = 1; nxt_target = 64'h1000;
        cycle("R8");
        idle(); #1; chk("R8", next_pc_out, 64'h1000); chk("R6", pc_out, 64'd8); @(negedge clk);
        idle(); commit = 1; nxt_load_rel = 1; nxt_target = -64'sd16;
        cycle("R8");
        idle(); #1; chk("R8", next_pc_out, 64'd8 - 64'd16); chk("R6", pc_out, 64'h1000);
        @(negedge clk);

        // R9: link save beats a register write to index 30
        idle(); link_save = 1; wr_en = 1; wr_idx = 30; wr_data = 64'h5555_5555_5555_5555;
        nxt_load_abs = 1; nxt_target = 64'h2000;
        cycle("R9");
        idle(); rd_a_idx = 30;
        #1; chk("R9", rd_a_data, 64'hFFFF_FFFF_FFFF_FFF8); @(negedge clk);

        // Mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            idle();
            wr_en        = ($urandom % 4) != 0;
            wr_idx       = 5'($urandom);
            wr_sp        = $urandom % 2;
            wr_narrow    = ($urandom % 3) == 0;
            wr_data      = {$urandom, $urandom};
            link_save    = ($urandom % 8) == 0;
            commit       = ($urandom % 3) == 0;
            nxt_load_abs = ($urandom % 10) == 0;
            nxt_load_rel = ($urandom % 10) == 0;
            nxt_target   = {$urandom, $urandom};
            rd_a_idx     = 5'($urandom); rd_a_sp = $urandom % 2;
            rd_a_size    = 2'($urandom); rd_a_signed = $urandom % 2;
            rd_b_idx     = 5'($urandom); rd_b_sp = $urandom % 2;
            rd_b_size    = 2'($urandom); rd_b_signed = $urandom % 2;
            cycle("");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule